// File: doc/BRIEF.md
# Banked Single-Port RAM with Per-Bank Enables

This block is a synchronous single-port memory of 2048 words by 8 bits. It is built from four separately enabled banks of 512 words each. Each cycle the caller presents a request, a write enable, an address and write data. The block raises the enable of exactly one bank, chosen from the top address bits, and only when a request is present. In idle cycles every bank stays off, which keeps the time each bank spends enabled to a minimum.

Reads complete in one clock cycle. The block registers which bank was read and steers that bank's output register to the read data port. The read port keeps its value in idle cycles. An elaboration-time parameter sets what the read port shows after a write. In write-first mode it shows the data just written. In no-change mode it keeps the value it held before the write. The memory accepts an access in every cycle, so the caller never waits and there is no back-pressure. The request and the write enable are plain level signals sampled on each rising clock edge. The bank enables are brought out as an output so that their activity can be observed.

Top module: `pwr_bank_ram`

## Requirements
- R1: A word written at any of the 2048 addresses is returned unchanged by a later read of that address, as long as no other write to that address comes in between.
- R2: In a cycle with `req` high, `bank_en` has exactly one bit set, and that bit's index equals `addr[10:9]`. Bank 0 holds addresses 0–511 and bank 3 holds addresses 1536–2047.
- R3: `bank_en` never has more than one bit set.
- R4: In a cycle with `req` low, `bank_en` is all zeros, no memory word changes whatever `wr_en`, `addr` and `wdata` carry, and `rdata` keeps its value in the next cycle.
- R5: A read (`req` high, `wr_en` low) puts the addressed word on `rdata` after the next rising clock edge, which is one cycle of latency.
- R6: With `WRITE_MODE` set to write-first, a write puts `wdata` on `rdata` after that clock edge.
- R7: With `WRITE_MODE` set to no-change, a write leaves `rdata` unchanged in the next cycle. This holds even when the write targets a different bank from the previous read.
- R8: While `rst_n` is low, `rdata` is 0. After reset, `bank_en` is 0 while `req` is low.
- R9: Words on either side of a bank boundary (511/512, 1023/1024, 1535/1536) and the end addresses 0 and 2047 are stored independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output and select registers |
| req | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read; ignored unless `req` is high |
| addr | input | 11 | Word address; bits [10:9] pick the bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the access |
| bank_en | output | 4 | Per-bank enables, one-hot or zero |

## Verification
A wrong bank decode shows on `bank_en` in the same cycle as the request. A wrong bank decode also corrupts data, and that shows on `rdata` the first time the affected word is read back. A stale or wrongly updated output-select register shows on `rdata` one cycle after the access, as a value from the wrong bank. In no-change mode it shows as a change across a write. Both write modes are exercised side by side, and each is compared against a behavioural model on every cycle, so any divergence is reported within one cycle of the access that exposes it.

// File: rtl/pwr_bank_ram_pkg.sv
package pwr_bank_ram_pkg;
  typedef enum logic {
    WM_WRITE_FIRST = 1'b0,
    WM_NO_CHANGE   = 1'b1
  } wmode_e;
endpackage

// File: rtl/pbr_decode.sv
module pbr_decode #(
  parameter int ADDR_W    = 11,
  parameter int NUM_BANKS = 4
) (
  input  logic                 req,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_en
);
  localparam int SEL_W = $clog2(NUM_BANKS);

  logic [SEL_W-1:0] sel;
  assign sel = addr[ADDR_W-1 -: SEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    assign bank_en[b] = req && (sel == SEL_W'(b));
  end
endmodule

// File: rtl/pbr_bank.sv
module pbr_bank #(
  parameter int DATA_W      = 8,
  parameter int WORD_W      = 9,
  parameter bit WRITE_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [WORD_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout
);
  localparam int WORDS = 2 ** WORD_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Storage array: touched only in enabled write cycles.
  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  // Output register: updates only while the bank is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (en) begin
      if (!we)              dout <= mem[addr];
      else if (WRITE_FIRST) dout <= wdata;
    end
  end
endmodule

// File: rtl/pwr_bank_ram.sv
module pwr_bank_ram
  import pwr_bank_ram_pkg::*;
#(
  parameter int     DATA_W     = 8,
  parameter int     BANK_WORDS = 512,
  parameter int     NUM_BANKS  = 4,
  parameter wmode_e WRITE_MODE = WM_WRITE_FIRST
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req,
  input  logic                                      wr_en,
  input  logic [$clog2(BANK_WORDS*NUM_BANKS)-1:0]   addr,
  input  logic [DATA_W-1:0]                         wdata,
  output logic [DATA_W-1:0]                         rdata,
  output logic [NUM_BANKS-1:0]                      bank_en
);
  localparam int  ADDR_W      = $clog2(BANK_WORDS * NUM_BANKS);
  localparam int  WORD_W      = $clog2(BANK_WORDS);
  localparam int  SEL_W       = $clog2(NUM_BANKS);
  localparam bit  WRITE_FIRST = (WRITE_MODE == WM_WRITE_FIRST);

  logic [DATA_W-1:0] bank_dout [NUM_BANKS];
  logic [SEL_W-1:0]  sel_q;
  logic              sel_load;

  pbr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_decode (
    .req     (req),
    .addr    (addr),
    .bank_en (bank_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pbr_bank #(
      .DATA_W      (DATA_W),
      .WORD_W      (WORD_W),
      .WRITE_FIRST (WRITE_FIRST)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[b]),
      .we    (wr_en),
      .addr  (addr[WORD_W-1:0]),
      .wdata (wdata),
      .dout  (bank_dout[b])
    );
  end

  // The output steering follows only accesses that refresh a bank output
  // register; in no-change mode a write must not switch the steering.
  assign sel_load = req && (!wr_en || WRITE_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= addr[ADDR_W-1 -: SEL_W];
  end

  assign rdata = bank_dout[sel_q];
endmodule

// File: rtl/pwr_bank_ram_chk.sv
module pwr_bank_ram_chk
  import pwr_bank_ram_pkg::*;
#(
  parameter int     DATA_W     = 8,
  parameter int     ADDR_W     = 11,
  parameter int     NUM_BANKS  = 4,
  parameter wmode_e WRITE_MODE = WM_WRITE_FIRST
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_BANKS-1:0] bank_en
);
  AST_BANK_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)); // R3

  AST_REQ_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones(bank_en) == 1)); // R2

  AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (bank_en == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(rdata)); // R4

  if (WRITE_MODE == WM_NO_CHANGE) begin : g_nc
    AST_NC_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr_en) |=> $stable(rdata)); // R7
  end else begin : g_wf
    AST_WF_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr_en) |=> (rdata == $past(wdata))); // R6
  end
endmodule

bind pwr_bank_ram pwr_bank_ram_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .NUM_BANKS  (NUM_BANKS),
  .WRITE_MODE (WRITE_MODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .bank_en (bank_en)
);

// File: tb/test_pwr_bank_ram.sv
module test_pwr_bank_ram;
  import pwr_bank_ram_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_wf, rdata_nc;
  logic [3:0]  bank_en_wf, bank_en_nc;

  int errors = 0;
  int checks = 0;

  logic [7:0] ref_mem [2048];
  logic [7:0] exp_wf = '0;
  logic [7:0] exp_nc = '0;
  string      tag_wf = "R8";
  string      tag_nc = "R8";

  always #10 clk = ~clk;  // 50 MHz

  pwr_bank_ram #(.WRITE_MODE(WM_WRITE_FIRST)) i_pwr_bank_ram (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_wf), .bank_en(bank_en_wf));

  pwr_bank_ram #(.WRITE_MODE(WM_NO_CHANGE)) i_pwr_bank_ram_nc (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_nc), .bank_en(bank_en_nc));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // One cycle: drive, check at the falling edge, update the model at the rising edge.
  task automatic step(input logic r, input logic w, input logic [10:0] a, input logic [7:0] d);
    logic [3:0] exp_en;
    req = r; wr_en = w; addr = a; wdata = d;
    exp_en = r ? (4'b0001 << a[10:9]) : 4'b0000;
    @(negedge clk);
    check(r ? "R2 bank_en wf" : "R4 bank_en wf", 32'(bank_en_wf), 32'(exp_en));
    check(r ? "R3 bank_en nc" : "R4 bank_en nc", 32'(bank_en_nc), 32'(exp_en));
    check({tag_wf, " rdata wf"}, 32'(rdata_wf), 32'(exp_wf));
    check({tag_nc, " rdata nc"}, 32'(rdata_nc), 32'(exp_nc));
    @(posedge clk);
    if (r) begin
      if (w) begin
        ref_mem[a] = d;
        exp_wf = d;
        tag_wf = "R6";
        tag_nc = "R7";
      end else begin
        exp_wf = ref_mem[a];
        exp_nc = ref_mem[a];
        tag_wf = "R5";
        tag_nc = "R5";
      end
    end else begin
      tag_wf = "R4";
      tag_nc = "R4";
    end
    #1;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R8: reset values
    @(negedge clk);
    check("R8 rdata wf", 32'(rdata_wf), 0);
    check("R8 rdata nc", 32'(rdata_nc), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    step(1'b0, 1'b0, 11'd0, 8'd0);  // R8: enables off after reset

    // R1: fill every address, then read all back
    for (int a = 0; a < 2048; a++) step(1'b1, 1'b1, 11'(a), pat(a));
    for (int a = 0; a < 2048; a++) step(1'b1, 1'b0, 11'(a), 8'h00);

    // R4: idle cycles with write-looking junk must change nothing
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 11'(i * 53), 8'(~i));
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 11'(i * 53), 8'h00);

    // R7: no-change write into a different bank than the last read
    step(1'b1, 1'b0, 11'd10, 8'h00);
    step(1'b1, 1'b1, 11'd1800, 8'hC3);
    step(1'b1, 1'b1, 11'd700, 8'h3C);
    step(1'b0, 1'b0, 11'd0, 8'h00);
    step(1'b1, 1'b0, 11'd1800, 8'h00);

    // R9: bank boundaries and end addresses
    begin
      int edges [8] = '{0, 511, 512, 1023, 1024, 1535, 1536, 2047};
      foreach (edges[k]) step(1'b1, 1'b1, 11'(edges[k]), 8'(8'hA0 + k));
      foreach (edges[k]) step(1'b1, 1'b0, 11'(edges[k]), 8'h00);
    end

    // R5/R6/R7/R4: random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rn = $urandom;
      step(rn[0] | rn[1], rn[2] & rn[3], rn[14:4], rn[22:15]);
    end
    step(1'b0, 1'b0, 11'd0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule